// File: doc/BRIEF.md
# Debug Stop Controller

This block decides when an executing instruction stream has to be stopped for debugging. It watches the retire strobe of the core and the instruction fetch strobe with its address. From these it raises a trap request to the exception logic, or a halt request to the run control. Single-instruction tracing requests one trap for every completed instruction. That trap is held back while the trap handler itself runs, which the core signals with a monitor-mode input. Two address comparators check every instruction fetch against programmable breakpoint addresses. A hit becomes a trap when software debugs itself. It becomes a halt when an attached hardware debugger owns the processor.

The block also takes mode commands from the hardware debugger: run, halt, single-step, reset and load-test-instruction. It reports the resulting run state to the core. In the load-test state, the run state tells the fetch unit to take instructions from the debugger's injection port instead of memory. All outputs are registered and change on the clock edge after the inputs that cause them.

Top module: `dbg_stop_ctrl`

## Requirements
- R1: After a synchronous reset, trap_req and halt_req are 0, bp_hits is 0 and run_state is RUN (0).
- R2: A retire strobe with trace_on=1 and monitor_mode=0 makes trap_req 1 in the next cycle. Each retire gives exactly one trap cycle, so back-to-back retires give back-to-back trap cycles. With trace_on=0, a retire gives no trap.
- R3: While monitor_mode=1, retires produce no trace trap, whatever trace_on is.
- R4: Comparator i hits only when fetch_vld=1, bp_en[i]=1 and fetch_addr equals slice i of bp_addr (bits i*AW upward). A disabled comparator, or a cycle without fetch_vld, never hits.
- R5: A breakpoint hit while emu_attached=0 makes trap_req 1 in the next cycle and leaves halt_req at 0.
- R6: A breakpoint hit while emu_attached=1 makes halt_req 1 in the next cycle and moves run_state to HALT (1). The trap that the hit would otherwise raise is not requested.
- R7: When both comparators hit on the same fetch, a single one-cycle stop event results. bp_hits (bit i = comparator i) is loaded with the hit vector on any cycle with a hit, so it shows 2'b11 in that case, and it holds its value otherwise.
- R8: A trace trap and a breakpoint trap arising in the same cycle give a single trap_req cycle.
- R9: A command strobe with cmd_code 0 (RUN), 1 (HALT), 2 (STEP), 3 (RESET) or 4 (LOAD_TEST) sets run_state to that same value in the next cycle. This takes priority over a breakpoint halt in the same cycle. Codes 5 to 7 are ignored.
- R10: In STEP (2), run_state stays STEP until one retire strobe arrives. It then becomes HALT (1) in the next cycle.
- R11: RESET (3) lasts exactly one cycle and is followed by RUN (0) unless a command or a breakpoint halt intervenes.
- R12: LOAD_TEST (4) holds until a command or a breakpoint halt arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | One instruction completed this cycle |
| fetch_vld | input | 1 | Instruction fetch address valid |
| fetch_addr | input | AW | Instruction fetch address |
| trace_on | input | 1 | Single-instruction tracing enabled |
| monitor_mode | input | 1 | Trap handler is executing |
| bp_en | input | NBP | Per-comparator enable |
| bp_addr | input | NBP*AW | Breakpoint addresses, comparator i in bits i*AW upward |
| emu_attached | input | 1 | Hardware debugger owns the processor |
| cmd_vld | input | 1 | Mode command strobe |
| cmd_code | input | 3 | Mode command code |
| trap_req | output | 1 | Trap request to the exception logic |
| halt_req | output | 1 | One-cycle halt request from a breakpoint |
| run_state | output | 3 | Current run state (encoding as cmd_code) |
| bp_hits | output | NBP | Comparators that hit on the last hitting fetch |

## Verification
The trace trap and a breakpoint trap can fall in the same cycle, when a retire with tracing enabled coincides with a fetch that hits a comparator. The bench provokes this with emu_attached low. It expects trap_req high for exactly that one following cycle and low in the cycle after, never a double event. A mode command and a breakpoint halt can also coincide. The bench applies both together and judges that run_state takes the commanded value.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_STEP  = 3'd2,
    ST_RESET = 3'd3,
    ST_LTI   = 3'd4
  } run_st_e;

  localparam logic [CMD_W-1:0] CMD_MAX = 3'd4;

  function automatic logic cmd_known(input logic [CMD_W-1:0] code);
    return code <= CMD_MAX;
  endfunction

endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] match_addr,
  output logic          hit
);

  always_comb begin
    hit = en && fetch_vld && (fetch_addr == match_addr);
  end

endmodule

// File: rtl/bkpt_bank.sv
module bkpt_bank #(
  parameter int AW  = 32,
  parameter int NBP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_vld,
  input  logic [AW-1:0]     fetch_addr,
  input  logic [NBP-1:0]    bp_en,
  input  logic [NBP*AW-1:0] bp_addr,
  output logic [NBP-1:0]    hits,
  output logic              any_hit,
  output logic [NBP-1:0]    hits_q
);

  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    bkpt_cmp #(.AW(AW)) u_cmp (
      .en         (bp_en[i]),
      .fetch_vld  (fetch_vld),
      .fetch_addr (fetch_addr),
      .match_addr (bp_addr[i*AW +: AW]),
      .hit        (hits[i])
    );
  end

  assign any_hit = |hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      hits_q <= '0;
    end else if (any_hit) begin
      hits_q <= hits;
    end
  end

  // R7
  hit_status_chk: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> hits_q == $past(hits));

  // R7
  hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_hit |=> $stable(hits_q));

  // R4
  no_fetch_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_vld |-> hits == '0);

endmodule

// File: rtl/trace_unit.sv
module trace_unit (
  input  logic clk,
  input  logic rst,
  input  logic retire_vld,
  input  logic trace_on,
  input  logic monitor_mode,
  input  logic bp_trap,
  output logic trap_req
);

  logic trace_hit;

  assign trace_hit = retire_vld && trace_on && !monitor_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
    end else begin
      trap_req <= trace_hit || bp_trap;
    end
  end

  // R2
  trace_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_vld && trace_on && !monitor_mode) |=> trap_req);

  // R3
  monitor_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (monitor_mode && !bp_trap) |=> !trap_req);

  // R8
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    (!retire_vld && !bp_trap) |=> !trap_req);

endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
  import dbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_vld,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             bp_halt,
  input  logic             retire_vld,
  output run_st_e          state_q,
  output logic             halt_req
);

  run_st_e state_d;

  always_comb begin
    state_d = state_q;
    if (cmd_vld && cmd_known(cmd_code)) begin
      state_d = run_st_e'(cmd_code);
    end else if (bp_halt) begin
      state_d = ST_HALT;
    end else begin
      case (state_q)
        ST_STEP:  if (retire_vld) state_d = ST_HALT;
        ST_RESET: state_d = ST_RUN;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      halt_req <= 1'b0;
    end else begin
      state_q  <= state_d;
      halt_req <= bp_halt;
    end
  end

  // R9
  cmd_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code <= 3'd4) |=> state_q == $past(cmd_code));

  // R6
  bp_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_halt && !cmd_vld) |=> (state_q == ST_HALT) && halt_req);

  // R10
  step_once_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STEP && retire_vld && !cmd_vld && !bp_halt) |=> state_q == ST_HALT);

  // R11
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESET && !cmd_vld && !bp_halt) |=> state_q == ST_RUN);

  // R12
  lti_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LTI && !cmd_vld && !bp_halt) |=> state_q == ST_LTI);

endmodule

// File: rtl/dbg_stop_ctrl.sv
module dbg_stop_ctrl
  import dbg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NBP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_vld,
  input  logic              fetch_vld,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              trace_on,
  input  logic              monitor_mode,
  input  logic [NBP-1:0]    bp_en,
  input  logic [NBP*AW-1:0] bp_addr,
  input  logic              emu_attached,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic              trap_req,
  output logic              halt_req,
  output logic [CMD_W-1:0]  run_state,
  output logic [NBP-1:0]    bp_hits
);

  logic [NBP-1:0] hits;
  logic           any_hit;
  logic           bp_trap;
  logic           bp_halt;
  run_st_e        state_q;

  bkpt_bank #(.AW(AW), .NBP(NBP)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .fetch_vld  (fetch_vld),
    .fetch_addr (fetch_addr),
    .bp_en      (bp_en),
    .bp_addr    (bp_addr),
    .hits       (hits),
    .any_hit    (any_hit),
    .hits_q     (bp_hits)
  );

  assign bp_trap = any_hit && !emu_attached;
  assign bp_halt = any_hit && emu_attached;

  trace_unit u_trace (
    .clk          (clk),
    .rst          (rst),
    .retire_vld   (retire_vld),
    .trace_on     (trace_on),
    .monitor_mode (monitor_mode),
    .bp_trap      (bp_trap),
    .trap_req     (trap_req)
  );

  run_ctrl u_run (
    .clk        (clk),
    .rst        (rst),
    .cmd_vld    (cmd_vld),
    .cmd_code   (cmd_code),
    .bp_halt    (bp_halt),
    .retire_vld (retire_vld),
    .state_q    (state_q),
    .halt_req   (halt_req)
  );

  assign run_state = state_q;

  // R5
  bp_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (any_hit && !emu_attached) |=> trap_req && !halt_req);

  // R6
  emu_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (any_hit && emu_attached && !retire_vld) |=> !trap_req);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!trap_req && !halt_req && bp_hits == '0 && run_state == 3'd0));

endmodule

// File: tb/test_dbg_stop_ctrl.sv
`timescale 1ns/1ps
module test_dbg_stop_ctrl;

  localparam int AW  = 8;
  localparam int NBP = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              retire_vld = 1'b0;
  logic              fetch_vld = 1'b0;
  logic [AW-1:0]     fetch_addr = '0;
  logic              trace_on = 1'b0;
  logic              monitor_mode = 1'b0;
  logic [NBP-1:0]    bp_en = '0;
  logic [NBP*AW-1:0] bp_addr = '0;
  logic              emu_attached = 1'b0;
  logic              cmd_vld = 1'b0;
  logic [2:0]        cmd_code = '0;
  logic              trap_req;
  logic              halt_req;
  logic [2:0]        run_state;
  logic [NBP-1:0]    bp_hits;

  int vectors = 0;
  int fails = 0;
  logic [2:0] exp_state = 3'd0;
  logic [1:0] exp_hits = 2'b00;

  always #2.5 clk = ~clk;

  dbg_stop_ctrl #(.AW(AW), .NBP(NBP)) i_dbg_stop_ctrl (
    .clk(clk), .rst(rst), .retire_vld(retire_vld), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .trace_on(trace_on), .monitor_mode(monitor_mode),
    .bp_en(bp_en), .bp_addr(bp_addr), .emu_attached(emu_attached),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code), .trap_req(trap_req),
    .halt_req(halt_req), .run_state(run_state), .bp_hits(bp_hits)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic apply(input string tag);
    logic [1:0] h;
    logic [2:0] ns;
    logic et, eh;
    h[0] = fetch_vld && bp_en[0] && (fetch_addr == bp_addr[AW-1:0]);
    h[1] = fetch_vld && bp_en[1] && (fetch_addr == bp_addr[2*AW-1:AW]);
    et = (retire_vld && trace_on && !monitor_mode) || ((h != 2'b00) && !emu_attached);
    eh = (h != 2'b00) && emu_attached;
    if (cmd_vld && cmd_code <= 3'd4) ns = cmd_code;
    else if (eh) ns = 3'd1;
    else if (exp_state == 3'd2 && retire_vld) ns = 3'd1;
    else if (exp_state == 3'd3) ns = 3'd0;
    else ns = exp_state;
    if (h != 2'b00) exp_hits = h;
    exp_state = ns;
    @(posedge clk);
    #1;
    vectors++;
    if (trap_req !== et || halt_req !== eh || run_state !== exp_state || bp_hits !== exp_hits) begin
      fails++;
      $display("FAIL %s: trap=%0b halt=%0b state=%0d hits=%b expected trap=%0b halt=%0b state=%0d hits=%b",
               tag, trap_req, halt_req, run_state, bp_hits, et, eh, exp_state, exp_hits);
    end
  endtask

  task automatic quiet();
    retire_vld = 0; fetch_vld = 0; cmd_vld = 0;
  endtask

  task automatic command(input logic [2:0] c, input string tag);
    quiet(); cmd_vld = 1; cmd_code = c;
    apply(tag);
    cmd_vld = 0;
  endtask

  task automatic hard_reset();
    rst = 1; quiet();
    repeat (2) @(posedge clk);
    #1;
    vectors++;
    if (trap_req !== 0 || halt_req !== 0 || run_state !== 3'd0 || bp_hits !== 2'b00) begin
      fails++;
      $display("FAIL R1: trap=%0b halt=%0b state=%0d hits=%b expected 0 0 0 00",
               trap_req, halt_req, run_state, bp_hits);
    end
    rst = 0; exp_state = 3'd0; exp_hits = 2'b00;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    hard_reset();
    apply("R1");

    // R2 / R3: every combination of retire, trace_on, monitor_mode, then a quiet cycle
    for (int c = 0; c < 8; c++) begin
      retire_vld = c[0]; trace_on = c[1]; monitor_mode = c[2];
      apply(c[2] ? "R3" : "R2");
      quiet(); apply("R2");
    end
    // R2: back-to-back retires give one trap per retire
    trace_on = 1; monitor_mode = 0; retire_vld = 1;
    repeat (4) apply("R2");
    quiet(); apply("R2");
    trace_on = 0;

    // R4 / R5 / R7: sweep all fetch addresses over every enable pattern, no debugger
    bp_addr = {8'hA5, 8'h3C};
    emu_attached = 0;
    for (int e = 0; e < 4; e++) begin
      bp_en = e[1:0];
      for (int a = 0; a < 256; a++) begin
        fetch_vld = 1; fetch_addr = a[7:0];
        apply(e == 0 ? "R4" : "R5");
      end
      fetch_vld = 0; fetch_addr = 8'h3C; apply("R4");
    end

    // R7: both comparators on one address
    bp_addr = {8'h77, 8'h77}; bp_en = 2'b11;
    for (int a = 0; a < 256; a++) begin
      fetch_vld = 1; fetch_addr = a[7:0];
      apply("R7");
    end
    quiet(); apply("R7");

    // R6: debugger attached, sweep addresses; hit halts
    bp_addr = {8'hA5, 8'h3C};
    emu_attached = 1;
    for (int a = 0; a < 256; a++) begin
      fetch_vld = 1; fetch_addr = a[7:0];
      apply("R6");
    end
    quiet(); apply("R6");
    command(3'd0, "R9");

    // R8: trace and breakpoint trap together
    emu_attached = 0; trace_on = 1; monitor_mode = 0;
    retire_vld = 1; fetch_vld = 1; fetch_addr = 8'h3C; bp_en = 2'b01;
    apply("R8");
    quiet(); apply("R8");
    trace_on = 0;

    // R9: every command code from RUN and from HALT
    for (int c = 0; c < 8; c++) begin
      command(3'd0, "R9");
      command(c[2:0], "R9");
      apply("R9");
      command(3'd1, "R9");
      command(c[2:0], "R9");
    end
    // R9: command beats a breakpoint halt in the same cycle
    emu_attached = 1; bp_en = 2'b11;
    cmd_vld = 1; cmd_code = 3'd0; fetch_vld = 1; fetch_addr = 8'hA5;
    apply("R9");
    quiet(); apply("R9");

    // R10: step waits for one retire then halts
    emu_attached = 0;
    command(3'd2, "R10");
    repeat (3) apply("R10");
    retire_vld = 1; apply("R10");
    quiet(); apply("R10");
    command(3'd2, "R10");
    retire_vld = 1; apply("R10");
    retire_vld = 1; apply("R10");

    // R11: reset state lasts one cycle
    command(3'd3, "R11");
    apply("R11");
    apply("R11");
    command(3'd3, "R11");
    emu_attached = 1; fetch_vld = 1; fetch_addr = 8'h3C;
    apply("R11");
    quiet(); emu_attached = 0;

    // R12: load-test state holds, breakpoint halt leaves it
    command(3'd4, "R12");
    repeat (3) apply("R12");
    retire_vld = 1; apply("R12");
    quiet(); emu_attached = 1; fetch_vld = 1; fetch_addr = 8'hA5;
    apply("R12");
    quiet(); emu_attached = 0; apply("R12");

    // R1: reset from a halted state with stored hits
    hard_reset();
    apply("R1");

    finish_run();
  end

endmodule